// File: doc/BRIEF.md
# Per-Period Oversampling Current Averager

This block paces analog-to-digital conversions of a sensed inductor current inside each switching period of a converter. At every period start it latches a sample count of 1, 2, 4 or 8. It then issues that many single-cycle conversion triggers, evenly spaced across the period. Each conversion result that comes back is passed straight on to the control loop. When the last sample of the period has been collected, the block also reports the mean of all the samples taken in that period. Sampling several times per period cancels most of the switching ripple, so the reported value tracks the average current rather than one point on the ripple.

A period start pulse, together with the period length in clock cycles, restarts the schedule. Results that were still in flight from the previous period are then dropped. If the period is too short to hold the requested number of samples, the block flags the condition and takes a single sample instead.

Top module: `ovs_avg_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `trig`, `smp_valid`, `avg_valid` and `cfg_err` are low, and `smp_data` and `avg_data` are zero.
- R2: The mode input code gives the number of triggers N issued in each period: 0 gives 1, 1 gives 2, 2 gives 4 and 3 gives 8. No further trigger is issued until the next start pulse.
- R3: The first trigger is high in the cycle after the clock edge that captures `period_start`. Trigger k (counting from 0) is high k·S cycles later, where S is `period_len` shifted right by log2(N).
- R4: A `adc_done` strobe is accepted only while fewer results than triggers have been collected in the current period. An accepted result appears on `smp_data` with `smp_valid` high in the next cycle.
- R5: In the cycle where the N-th result of a period appears on `smp_data`, `avg_valid` is high. `avg_data` then equals the sum of that period's N results shifted right by log2(N).
- R6: A start pulse clears the trigger schedule and the sum. A `adc_done` strobe in the start cycle, or one that arrives later with no conversion outstanding (for example, one left over from the previous period), is dropped and produces no `smp_valid`.
- R7: `os_mode` is sampled only at a start pulse. Changing it in the middle of a period has no effect on the triggers of that period.
- R8: If `period_len` is less than the requested N, `cfg_err` goes high from the cycle after the start pulse until the next start pulse. The period then runs with a single trigger at offset 0 and an average equal to that one result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_start | input | 1 | One-cycle pulse that begins a switching period |
| period_len | input | PERIOD_W | Period length in clock cycles, captured at the start pulse |
| os_mode | input | 2 | Sample-count code, captured at the start pulse |
| adc_data | input | DATA_W | Conversion result |
| adc_done | input | 1 | Strobe marking `adc_data` as valid |
| trig | output | 1 | Start-of-conversion pulse |
| smp_data | output | DATA_W | Latest accepted result |
| smp_valid | output | 1 | `smp_data` is new this cycle |
| avg_data | output | DATA_W | Mean of the period's results |
| avg_valid | output | 1 | `avg_data` is new this cycle |
| cfg_err | output | 1 | Period too short for the requested count |

## Verification
The bench uses the default parameters: a 16-bit period length and 12-bit samples. With these values the 8-sample sum of up to 32760 fits the 15-bit accumulator, so the average arithmetic is exercised at full scale. Period lengths are drawn from 0 to 99, which covers spacings of one cycle, zero-length periods and periods shorter than the sample count. Each period is restarted at a random point, sometimes before its conversions have returned, so leftover results from the previous period and mid-period mode changes both occur often.

// File: rtl/ovs_pkg.sv
package ovs_pkg;
  typedef enum logic [1:0] {
    OS_X1 = 2'd0,
    OS_X2 = 2'd1,
    OS_X4 = 2'd2,
    OS_X8 = 2'd3
  } os_mode_e;

  localparam int CNT_W = 4;

  // number of samples selected by a log2 code
  function automatic logic [CNT_W-1:0] os_count(input logic [1:0] lg);
    return 4'b0001 << lg;
  endfunction
endpackage

// File: rtl/ovs_trig_gen.sv
module ovs_trig_gen
  import ovs_pkg::*;
#(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [PERIOD_W-1:0] len,
  input  logic [1:0]          mode,
  output logic                trig,
  output logic [CNT_W-1:0]    issued,
  output logic [1:0]          log_act,
  output logic [CNT_W-1:0]    n_act,
  output logic                cfg_err
);
  logic                active;
  logic [PERIOD_W-1:0] cnt;
  logic [PERIOD_W-1:0] next_at;
  logic [PERIOD_W-1:0] spacing;
  logic [CNT_W-1:0]    n_req;
  logic                too_short;
  logic [1:0]          lg_sel;
  logic                running;

  always_comb begin
    n_req     = os_count(mode);
    too_short = len < {{(PERIOD_W-CNT_W){1'b0}}, n_req};
    lg_sel    = too_short ? 2'd0 : mode;
    running   = active && (issued < n_act);
    trig      = running && (cnt == next_at);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      cnt     <= '0;
      next_at <= '0;
      spacing <= '0;
      issued  <= '0;
      log_act <= '0;
      n_act   <= '0;
      cfg_err <= 1'b0;
    end else if (start) begin
      active  <= 1'b1;
      cnt     <= '0;
      next_at <= '0;
      spacing <= len >> lg_sel;
      issued  <= '0;
      log_act <= lg_sel;
      n_act   <= os_count(lg_sel);
      cfg_err <= too_short;
    end else if (running) begin
      cnt <= cnt + 1'b1;
      if (trig) begin
        issued  <= issued + 1'b1;
        next_at <= next_at + spacing;
      end
    end
  end
endmodule

// File: rtl/ovs_accum.sv
module ovs_accum
  import ovs_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              adc_done,
  input  logic [DATA_W-1:0] adc_data,
  input  logic [CNT_W-1:0]  issued,
  input  logic [CNT_W-1:0]  n_act,
  input  logic [1:0]        log_act,
  output logic              smp_valid,
  output logic [DATA_W-1:0] smp_data,
  output logic              avg_valid,
  output logic [DATA_W-1:0] avg_data
);
  localparam int ACC_W = DATA_W + 3;

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] acc_nxt;
  logic [CNT_W-1:0] got;
  logic             accept;
  logic             last;

  function automatic logic [DATA_W-1:0] avg_of(input logic [ACC_W-1:0] s,
                                               input logic [1:0] lg);
    logic [ACC_W-1:0] t;
    t = s >> lg;
    return t[DATA_W-1:0];
  endfunction

  always_comb begin
    accept  = adc_done && !start && (issued > got);
    last    = accept && (CNT_W'(got + 1'b1) == n_act);
    acc_nxt = acc + {{(ACC_W-DATA_W){1'b0}}, adc_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc       <= '0;
      got       <= '0;
      smp_valid <= 1'b0;
      smp_data  <= '0;
      avg_valid <= 1'b0;
      avg_data  <= '0;
    end else if (start) begin
      acc       <= '0;
      got       <= '0;
      smp_valid <= 1'b0;
      avg_valid <= 1'b0;
    end else begin
      smp_valid <= accept;
      avg_valid <= last;
      if (accept) begin
        smp_data <= adc_data;
        acc      <= acc_nxt;
        got      <= got + 1'b1;
      end
      if (last) avg_data <= avg_of(acc_nxt, log_act);
    end
  end
endmodule

// File: rtl/ovs_avg_top.sv
module ovs_avg_top
  import ovs_pkg::*;
#(
  parameter int PERIOD_W = 16,
  parameter int DATA_W   = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                period_start,
  input  logic [PERIOD_W-1:0] period_len,
  input  logic [1:0]          os_mode,
  input  logic [DATA_W-1:0]   adc_data,
  input  logic                adc_done,
  output logic                trig,
  output logic [DATA_W-1:0]   smp_data,
  output logic                smp_valid,
  output logic [DATA_W-1:0]   avg_data,
  output logic                avg_valid,
  output logic                cfg_err
);
  logic             start_evt;
  logic [CNT_W-1:0] issued;
  logic [CNT_W-1:0] n_act;
  logic [1:0]       log_act;

  assign start_evt = period_start;

  ovs_trig_gen #(.PERIOD_W(PERIOD_W)) i_trig (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start_evt),
    .len     (period_len),
    .mode    (os_mode),
    .trig    (trig),
    .issued  (issued),
    .log_act (log_act),
    .n_act   (n_act),
    .cfg_err (cfg_err)
  );

  ovs_accum #(.DATA_W(DATA_W)) i_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_evt),
    .adc_done  (adc_done),
    .adc_data  (adc_data),
    .issued    (issued),
    .n_act     (n_act),
    .log_act   (log_act),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .avg_valid (avg_valid),
    .avg_data  (avg_data)
  );
endmodule

// File: rtl/ovs_avg_chk.sv
module ovs_avg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_evt,
  input logic       trig,
  input logic       smp_valid,
  input logic       avg_valid,
  input logic       adc_done,
  input logic       cfg_err,
  input logic [1:0] log_act,
  input logic [3:0] n_act
);
  logic [3:0] tcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         tcnt <= '0;
    else if (start_evt) tcnt <= '0;
    else if (trig)      tcnt <= tcnt + 1'b1;
  end

  a_r2_trig_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !start_evt) |-> (tcnt < n_act));

  a_r4_sample_from_done: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> $past(adc_done));

  a_r5_avg_with_last: assert property (@(posedge clk) disable iff (!rst_n)
    avg_valid |-> smp_valid);

  a_r6_start_flush: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (!smp_valid && !avg_valid));

  a_r7_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    !start_evt |=> $stable(log_act));

  a_r8_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && trig) |-> (tcnt == 4'd0));
endmodule

bind ovs_avg_top ovs_avg_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_evt (start_evt),
  .trig      (trig),
  .smp_valid (smp_valid),
  .avg_valid (avg_valid),
  .adc_done  (adc_done),
  .cfg_err   (cfg_err),
  .log_act   (log_act),
  .n_act     (n_act)
);

// File: tb/test_ovs_avg_top.sv
`timescale 1ns/1ps
module test_ovs_avg_top;
  localparam int PW  = 16;
  localparam int DW  = 12;
  localparam int LAT = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          period_start;
  logic [PW-1:0] period_len;
  logic [1:0]    os_mode;
  logic [DW-1:0] adc_data;
  logic          adc_done;
  logic          trig;
  logic [DW-1:0] smp_data;
  logic          smp_valid;
  logic [DW-1:0] avg_data;
  logic          avg_valid;
  logic          cfg_err;

  int n_checks = 0;
  int n_fail   = 0;

  // bench model of the requirements
  bit m_active;
  int m_cnt, m_next, m_sp, m_idx, m_n, m_lg, m_got, m_acc;
  bit e_sv, e_av, e_err;
  int e_sd, e_ad;
  bit [LAT-1:0] pipe;

  always #2 clk = ~clk;

  ovs_avg_top #(.PERIOD_W(PW), .DATA_W(DW)) i_ovs_avg_top (
    .clk(clk), .rst_n(rst_n), .period_start(period_start),
    .period_len(period_len), .os_mode(os_mode), .adc_data(adc_data),
    .adc_done(adc_done), .trig(trig), .smp_data(smp_data),
    .smp_valid(smp_valid), .avg_data(avg_data), .avg_valid(avg_valid),
    .cfg_err(cfg_err));

  function automatic int f_count(input int code);
    return 1 << code;
  endfunction

  function automatic bit f_short(input int len, input int code);
    return len < f_count(code);
  endfunction

  function automatic int f_mean(input int sum, input int lg);
    return sum / f_count(lg);
  endfunction

  function automatic bit f_trig();
    return m_active && (m_idx < m_n) && (m_cnt == m_next);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    bit t;
    bit acc_ok;
    t = f_trig();
    if (period_start) begin
      e_err    = f_short(int'(period_len), int'(os_mode));
      m_lg     = e_err ? 0 : int'(os_mode);
      m_n      = f_count(m_lg);
      m_sp     = int'(period_len) / m_n;
      m_cnt    = 0; m_next = 0; m_idx = 0; m_active = 1;
      m_got    = 0; m_acc = 0; e_sv = 0; e_av = 0;
    end else begin
      acc_ok = adc_done && (m_idx > m_got);
      e_sv = acc_ok;
      e_av = 0;
      if (acc_ok) begin
        e_sd  = int'(adc_data);
        m_acc = m_acc + int'(adc_data);
        m_got++;
        if (m_got == m_n) begin
          e_av = 1;
          e_ad = f_mean(m_acc, m_lg);
        end
      end
      if (m_active && m_idx < m_n) begin
        m_cnt++;
        if (t) begin
          m_idx++;
          m_next += m_sp;
        end
      end
    end
  endtask

  task automatic compare();
    bit et;
    et = f_trig();
    check(trig == et, "R2 R3 R7 trig", int'(trig), int'(et));
    check(smp_valid == e_sv, "R4 R6 smp_valid", int'(smp_valid), int'(e_sv));
    if (e_sv) check(int'(smp_data) == e_sd, "R4 smp_data", int'(smp_data), e_sd);
    check(avg_valid == e_av, "R5 avg_valid", int'(avg_valid), int'(e_av));
    if (e_av) check(int'(avg_data) == e_ad, "R5 avg_data", int'(avg_data), e_ad);
    check(cfg_err == e_err, "R8 cfg_err", int'(cfg_err), int'(e_err));
  endtask

  // one clock: model follows the edge, outputs compared at the falling edge,
  // then the ADC stand-in is driven for the next edge
  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
    pipe = {pipe[LAT-2:0], f_trig()};
    adc_done = pipe[LAT-1] | (($urandom % 16) == 0);
    adc_data = DW'($urandom);
  endtask

  task automatic run_period(input int code, input int len, input int run, input bit wiggle);
    period_start = 1'b1;
    os_mode      = 2'(code);
    period_len   = PW'(len);
    step();
    period_start = 1'b0;
    if (wiggle) os_mode = 2'(~code);   // R7: ignored until the next start
    for (int i = 1; i < run; i++) step();
  endtask

  initial begin
    #700000;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h0005eed1));
    rst_n = 1'b0; period_start = 1'b0; period_len = '0; os_mode = '0;
    adc_data = '0; adc_done = 1'b0; pipe = '0;
    m_active = 0; m_cnt = 0; m_next = 0; m_sp = 0; m_idx = 0; m_n = 0;
    m_lg = 0; m_got = 0; m_acc = 0;
    e_sv = 0; e_av = 0; e_err = 0; e_sd = 0; e_ad = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(trig == 0 && smp_valid == 0 && avg_valid == 0 && cfg_err == 0,
          "R1 reset flags", int'({trig, smp_valid, avg_valid, cfg_err}), 0);
    check(smp_data == 0 && avg_data == 0, "R1 reset data",
          int'(smp_data) + int'(avg_data), 0);
    rst_n = 1'b1;
    step();
    check(trig == 0 && smp_valid == 0, "R1 after release",
          int'({trig, smp_valid}), 0);
    // directed corners
    run_period(3, 64, 72, 0);   // R2 R3 R5 full 8x
    run_period(3, 5, 10, 0);    // R8 too short for 8
    run_period(0, 0, 5, 1);     // zero length, single sample, R7 wiggle
    run_period(2, 4, 9, 0);     // spacing of one cycle
    run_period(3, 8, 12, 1);    // 8x at spacing one, R7
    run_period(1, 30, 8, 0);    // early restart: R6 leftover results
    run_period(2, 40, 44, 1);
    run_period(1, 1, 6, 0);     // R8 with 2x
    for (int p = 0; p < 300; p++) begin
      int len;
      len = int'($urandom % 100);
      run_period(int'($urandom % 4), len, 1 + int'($urandom % (len + 12)),
                 bit'($urandom % 2));
    end
    repeat (LAT + 2) step();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule